// File: doc/BRIEF.md
# Video Port Pixel Input Unpacker

This block receives words from an upstream pixel pipeline over a 16-bit video port and passes them on to a resizing stage. The port carries a horizontal sync that marks a line, a vertical sync that marks a frame, and an optional write-enable strobe. At the start of each line, the block decides whether the write-enable strobe gates the data. It then splits each accepted word into luma, chroma or raw lanes according to the pixel format of that line.

The write-enable gating mode and the format are configuration inputs. They are captured only when HD rises and stay fixed until the next line starts. The upstream side can therefore change them at any time without corrupting a line in flight. Every accepted word appears on the registered outputs one cycle later. A per-line word count is reported, with a done pulse, when the next line begins.

Top module: `vp_unpack`

## Requirements
- R1: A word is accepted when `hd_i` and `vd_i` are both high and either the latched gating mode is 0 or `we_i` is 1. With the mode at 0, `we_i` has no effect.
- R2: `we_mode_i` is captured in the cycle where `hd_i` goes from 0 to 1. The captured value applies to that cycle's word and to the rest of the line, and changes made mid-line are ignored.
- R3: `fmt_i` is captured in the same way as `we_mode_i`. Its encoding is 0 = raw 16-bit, 1 = interleaved 4:2:2, 2 = 4:2:0 luma pass, 3 = 4:2:0 chroma pass.
- R4: In raw mode, `raw_o` carries the whole accepted word, bit 15 as MSB, and `luma_o` and `chroma_o` are 0.
- R5: In 4:2:2 mode, `luma_o` = word[15:8], `chroma_o` = word[7:0], and `raw_o` is 0.
- R6: In 4:2:0 luma pass, `luma_o` = word[15:8], and `chroma_o` and `raw_o` are 0.
- R7: In 4:2:0 chroma pass, `chroma_o` = word[7:0], and `luma_o` and `raw_o` are 0.
- R8: In 4:2:2 and chroma pass modes, `cr_phase_o` is 0 (Cb) for the first accepted word of a line and toggles on each further accepted word. It is 0 in the other modes.
- R9: `valid_o` rises exactly one cycle after an accepted word. While `valid_o` is 0, all data outputs and `cr_phase_o` are 0.
- R10: On each HD rising edge after the first line since reset, `line_done_o` pulses for one cycle, one cycle after the edge. With it, `line_cnt_o` shows the number of words accepted in the previous line, saturating at 2^CNT_W-1. `line_cnt_o` holds between pulses.
- R11: An active-low asynchronous reset clears the outputs, the latched modes, the phase and the counters. The first line after reset produces no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 16 | Video port data word |
| hd_i | input | 1 | Horizontal sync / line active |
| vd_i | input | 1 | Vertical sync / frame active |
| we_i | input | 1 | Upstream write-enable strobe |
| we_mode_i | input | 1 | 1: `we_i` gates data |
| fmt_i | input | 2 | Pixel format select |
| valid_o | output | 1 | Output word valid |
| luma_o | output | 8 | Luma byte |
| chroma_o | output | 8 | Chroma byte |
| cr_phase_o | output | 1 | 0 = Cb, 1 = Cr |
| raw_o | output | 16 | Raw 16-bit sample |
| line_cnt_o | output | CNT_W | Accepted words in last line |
| line_done_o | output | 1 | Line count update pulse |

## Verification
The assertions assume that HD is a level which stays low for at least one cycle between lines, so two line starts are never adjacent. They also assume that words arrive only while HD is high. The directed stimulus always drops HD for two cycles between lines and drives every input at the falling clock edge. The configuration inputs are changed freely in mid-line, to exercise the capture rule. The write-enable strobe is toggled in both gating modes, so the bench covers the case where the strobe should matter and the case where it must be ignored.

// File: rtl/vp_unpack_pkg.sv
package vp_unpack_pkg;
  typedef enum logic [1:0] {
    FMT_RAW16 = 2'b00,
    FMT_YC422 = 2'b01,
    FMT_Y420  = 2'b10,
    FMT_C420  = 2'b11
  } vp_fmt_e;
endpackage

// File: rtl/vp_line_ctrl.sv
module vp_line_ctrl
  import vp_unpack_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hd_i,
  input  logic       vd_i,
  input  logic       we_i,
  input  logic       we_mode_i,
  input  logic [1:0] fmt_i,
  output logic       hd_rise_o,
  output logic       qual_o,
  output vp_fmt_e    fmt_o,
  output logic       cr_ph_o
);
  logic    hd_q, wem_q, ph_q, wem_eff, chroma_fmt;
  vp_fmt_e fmt_q;

  assign hd_rise_o  = hd_i & ~hd_q;
  // modes take effect in the edge cycle itself
  assign wem_eff    = hd_rise_o ? we_mode_i : wem_q;
  assign fmt_o      = hd_rise_o ? vp_fmt_e'(fmt_i) : fmt_q;
  assign qual_o     = hd_i & vd_i & (~wem_eff | we_i);
  assign chroma_fmt = (fmt_o == FMT_YC422) || (fmt_o == FMT_C420);
  assign cr_ph_o    = hd_rise_o ? 1'b0 : ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hd_q  <= 1'b0;
      wem_q <= 1'b0;
      fmt_q <= FMT_RAW16;
      ph_q  <= 1'b0;
    end else begin
      hd_q <= hd_i;
      if (hd_rise_o) begin
        wem_q <= we_mode_i;
        fmt_q <= vp_fmt_e'(fmt_i);
      end
      if (qual_o && chroma_fmt) ph_q <= ~cr_ph_o;
      else if (hd_rise_o)       ph_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vp_lane_mux.sv
module vp_lane_mux
  import vp_unpack_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  localparam int unsigned WORD_W = 2 * PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              qual_i,
  input  vp_fmt_e           fmt_i,
  input  logic              cr_ph_i,
  output logic              valid_o,
  output logic [PIX_W-1:0]  luma_o,
  output logic [PIX_W-1:0]  chroma_o,
  output logic              cr_phase_o,
  output logic [WORD_W-1:0] raw_o
);
  logic [PIX_W-1:0] hi_byte, lo_byte;
  assign hi_byte = data_i[WORD_W-1:PIX_W];
  assign lo_byte = data_i[PIX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      luma_o     <= '0;
      chroma_o   <= '0;
      cr_phase_o <= 1'b0;
      raw_o      <= '0;
    end else begin
      valid_o    <= qual_i;
      luma_o     <= '0;
      chroma_o   <= '0;
      cr_phase_o <= 1'b0;
      raw_o      <= '0;
      if (qual_i) begin
        unique case (fmt_i)
          FMT_RAW16: raw_o <= data_i;
          FMT_YC422: begin
            luma_o     <= hi_byte;
            chroma_o   <= lo_byte;
            cr_phase_o <= cr_ph_i;
          end
          FMT_Y420:  luma_o <= hi_byte;
          FMT_C420: begin
            chroma_o   <= lo_byte;
            cr_phase_o <= cr_ph_i;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vp_line_count.sv
module vp_line_count #(
  parameter int unsigned CNT_W = 12,
  localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hd_rise_i,
  input  logic             qual_i,
  output logic [CNT_W-1:0] line_cnt_o,
  output logic             line_done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      seen_q      <= 1'b0;
      line_cnt_o  <= '0;
      line_done_o <= 1'b0;
    end else begin
      line_done_o <= hd_rise_i & seen_q;
      if (hd_rise_i) begin
        seen_q <= 1'b1;
        if (seen_q) line_cnt_o <= cnt_q;
        cnt_q <= qual_i ? CNT_W'(1) : '0;
      end else if (qual_i && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vp_unpack.sv
module vp_unpack
  import vp_unpack_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned CNT_W = 12,
  localparam int unsigned WORD_W = 2 * PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              hd_i,
  input  logic              vd_i,
  input  logic              we_i,
  input  logic              we_mode_i,
  input  logic [1:0]        fmt_i,
  output logic              valid_o,
  output logic [PIX_W-1:0]  luma_o,
  output logic [PIX_W-1:0]  chroma_o,
  output logic              cr_phase_o,
  output logic [WORD_W-1:0] raw_o,
  output logic [CNT_W-1:0]  line_cnt_o,
  output logic              line_done_o
);
  logic    hd_rise, qual, cr_ph;
  vp_fmt_e fmt_cur;

  vp_line_ctrl u_ctrl (
    .clk_i, .rst_ni, .hd_i, .vd_i, .we_i, .we_mode_i, .fmt_i,
    .hd_rise_o(hd_rise), .qual_o(qual), .fmt_o(fmt_cur), .cr_ph_o(cr_ph)
  );

  vp_lane_mux #(.PIX_W(PIX_W)) u_mux (
    .clk_i, .rst_ni, .data_i,
    .qual_i(qual), .fmt_i(fmt_cur), .cr_ph_i(cr_ph),
    .valid_o, .luma_o, .chroma_o, .cr_phase_o, .raw_o
  );

  vp_line_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .hd_rise_i(hd_rise), .qual_i(qual),
    .line_cnt_o, .line_done_o
  );
endmodule

// File: rtl/vp_unpack_chk.sv
module vp_unpack_chk #(
  parameter int unsigned PIX_W = 8,
  localparam int unsigned WORD_W = 2 * PIX_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hd_i,
  input logic              vd_i,
  input logic              valid_o,
  input logic [PIX_W-1:0]  luma_o,
  input logic [PIX_W-1:0]  chroma_o,
  input logic              cr_phase_o,
  input logic [WORD_W-1:0] raw_o,
  input logic              line_done_o
);
  assert_valid_in_line_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(hd_i && vd_i));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (luma_o == '0 && chroma_o == '0 && raw_o == '0 && !cr_phase_o));

  // raw lane excludes the byte lanes
  assert_raw_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o != '0) |-> (luma_o == '0 && chroma_o == '0 && !cr_phase_o));

  assert_done_after_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> ($past(hd_i) && !$past(hd_i, 2)));

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> !line_done_o);
endmodule

bind vp_unpack vp_unpack_chk #(.PIX_W(PIX_W)) u_vp_unpack_chk (
  .clk_i, .rst_ni, .hd_i, .vd_i, .valid_o, .luma_o, .chroma_o,
  .cr_phase_o, .raw_o, .line_done_o
);

// File: tb/vp_unpack_tb_top.sv
module vp_unpack_tb_top;
  localparam int CNT_W   = 12;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] data_i = '0;
  logic        hd_i = 1'b0, vd_i = 1'b0, we_i = 1'b0, we_mode_i = 1'b0;
  logic [1:0]  fmt_i = 2'd0;
  logic        valid_o, cr_phase_o, line_done_o;
  logic [7:0]  luma_o, chroma_o;
  logic [15:0] raw_o;
  logic [CNT_W-1:0] line_cnt_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model state
  logic       m_hd = 0, m_wem = 0, m_ph = 0, m_seen = 0;
  logic [1:0] m_fmt = 0;
  int         m_cnt = 0, m_lc = 0;

  always #4 clk_i = ~clk_i;

  vp_unpack #(.CNT_W(CNT_W)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_hd = 0; m_wem = 0; m_ph = 0; m_seen = 0; m_fmt = 0; m_cnt = 0; m_lc = 0;
  endtask

  task automatic drive(input logic hd, input logic vd, input logic we,
                       input logic wem, input logic [1:0] fmt, input logic [15:0] d);
    logic rise, q, cf, e_ph, e_done;
    logic [15:0] e_raw;
    logic [7:0] e_l, e_c;
    string lane;
    rise = hd && !m_hd;
    if (rise) begin m_wem = wem; m_fmt = fmt; m_ph = 0; end
    q    = hd && vd && (!m_wem || we);
    cf   = (m_fmt == 2'd1) || (m_fmt == 2'd3);
    e_ph = q && cf ? m_ph : 1'b0;
    if (q && cf) m_ph = !m_ph;
    e_raw = (q && m_fmt == 2'd0) ? d : 16'h0;
    e_l   = (q && (m_fmt == 2'd1 || m_fmt == 2'd2)) ? d[15:8] : 8'h0;
    e_c   = (q && cf) ? d[7:0] : 8'h0;
    e_done = rise && m_seen;
    if (e_done) m_lc = m_cnt;
    if (rise) begin m_seen = 1; m_cnt = q ? 1 : 0; end
    else if (q && m_cnt != CNT_MAX) m_cnt++;
    m_hd = hd;
    hd_i = hd; vd_i = vd; we_i = we; we_mode_i = wem; fmt_i = fmt; data_i = d;
    @(negedge clk_i);
    chk(valid_o == q, "R1 valid", valid_o, q);
    case (m_fmt)
      2'd0: lane = "R4 raw lanes";
      2'd1: lane = "R5 422 lanes";
      2'd2: lane = "R6 luma lanes";
      default: lane = "R7 chroma lanes";
    endcase
    if (!q) lane = "R9 idle lanes";
    chk(raw_o == e_raw && luma_o == e_l && chroma_o == e_c, lane,
        {raw_o, luma_o, chroma_o}, {e_raw, e_l, e_c});
    chk(cr_phase_o == e_ph, "R8 phase", cr_phase_o, e_ph);
    chk(line_done_o == e_done, "R10 done", line_done_o, e_done);
    chk(line_cnt_o == CNT_W'(m_lc), "R10 count", line_cnt_o, m_lc);
  endtask

  task automatic gap();
    repeat (2) drive(0, 1, 0, 0, 0, 16'h0);
  endtask

  task automatic t_reset();
    chk(valid_o == 0 && raw_o == 0 && luma_o == 0 && chroma_o == 0 &&
        cr_phase_o == 0 && line_done_o == 0 && line_cnt_o == 0,
        "R11 reset outputs", {valid_o, raw_o, line_cnt_o}, 0);
  endtask

  task automatic t_raw();
    for (int i = 0; i < 6; i++) drive(1, 1, 0, 0, 2'd0, 16'hA5C3 + 16'(i * 16'h1111));
    gap();
  endtask

  task automatic t_422_free();  // R1: we ignored with mode 0
    for (int i = 0; i < 8; i++) drive(1, 1, i[0], 0, 2'd1, {8'(8'h10 + i), 8'(8'h80 + i)});
    gap();
  endtask

  task automatic t_422_gated();  // R8: phase toggles only on accepted words
    for (int i = 0; i < 9; i++) drive(1, 1, (i % 3) != 1, 1, 2'd1, {8'(8'h20 + i), 8'(8'h40 + i)});
    gap();
  endtask

  task automatic t_midline_modes();
    drive(1, 1, 1, 1, 2'd2, 16'h7E11);
    drive(1, 1, 1, 1, 2'd2, 16'h6D22);
    drive(1, 1, 0, 0, 2'd0, 16'h5C33);  // mode changes ignored
    chk(valid_o == 0, "R2 midline gating kept", valid_o, 0);
    drive(1, 1, 1, 0, 2'd0, 16'h4B44);
    chk(luma_o == 8'h4B && raw_o == 0, "R3 midline format kept", raw_o, 16'h0);
    gap();
  endtask

  task automatic t_luma();
    for (int i = 0; i < 4; i++) drive(1, 1, 0, 0, 2'd2, 16'hF0F0 ^ 16'(i));
    gap();
  endtask

  task automatic t_chroma();
    for (int i = 0; i < 5; i++) drive(1, 1, 1, 1, 2'd3, {8'hEE, 8'(8'h30 + i)});
    gap();
  endtask

  task automatic t_vd_low();  // R1: no frame, no words
    for (int i = 0; i < 3; i++) drive(1, 0, 1, 0, 2'd0, 16'hBEEF);
    drive(1, 1, 1, 0, 2'd0, 16'h1234);
    gap();
  endtask

  task automatic t_saturate();  // R10
    for (int i = 0; i < CNT_MAX + 5; i++) drive(1, 1, 1, 0, 2'd0, 16'(i + 1));
    gap();
    drive(1, 1, 1, 0, 2'd0, 16'h0001);
    chk(line_cnt_o == CNT_W'(CNT_MAX), "R10 saturation", line_cnt_o, CNT_MAX);
    gap();
  endtask

  task automatic t_mid_reset();  // R11
    drive(1, 1, 1, 1, 2'd1, 16'h1122);
    #1 rst_ni = 0;
    model_reset();
    hd_i = 0;
    @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    gap();
    drive(1, 1, 1, 0, 2'd0, 16'h0F0F);
    chk(line_done_o == 0, "R11 no done after reset", line_done_o, 0);
    gap();
    drive(1, 1, 1, 0, 2'd0, 16'h0F0F);
    gap();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_raw();
    t_422_free();
    t_422_gated();
    t_midline_modes();
    t_luma();
    t_chroma();
    t_vd_low();
    drive(1, 1, 1, 0, 2'd0, 16'h0);  // flush last count
    gap();
    t_saturate();
    t_mid_reset();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule